// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Controller

This block watches seven general-purpose input pins and turns their transitions into interrupt requests. Every pin has two independent detection lanes, one for rising transitions and one for falling transitions, and each lane has its own enable bit. A pin can therefore interrupt on a rise, on a fall, or on either. A transition seen on an enabled lane sets a sticky pending flag. The flag stays set until software writes a one to the matching position of the clear register.

The inputs are asynchronous. They pass through a two-flop synchronizer, and a transition is found by comparing the synchronized value with its value one cycle earlier. The block drives one request line that is high while any flag is pending. Next to it sits a vector number: a programmable base plus the index of the lowest-numbered pin that has any flag pending.

Software reaches three word registers over a simple single-cycle bus. Word 0 is the enable register. Word 1 is the clear register on write and the pending flags on read. Word 2 is the vector base.

Top module: `gpio_edge_intc`

## Requirements
- R1: After reset the enable register, the pending flags and the vector base all read 0, and `irq_o` is low.
- R2: In the enable register at word 0, bit n enables rising detection on pin n and bit n+8 enables falling detection on pin n. Written values read back, and bits 7 and 15 always read 0.
- R3: A 0-to-1 change on pin n while its rising enable is set makes pending bit n readable at word 1 by the third rising clock edge after the change.
- R4: A 1-to-0 change on pin n while its falling enable is set sets pending bit n+8 at word 1, with the same latency as R3.
- R5: A change whose lane enable is clear sets no pending bit.
- R6: Writing word 1 clears every pending bit written as 1 and leaves pending bits written as 0 unchanged.
- R7: If a clear write and a new enabled transition hit the same pending bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when at least one pending bit is set.
- R9: The vector base at word 2 is an 8-bit read/write register. `vector_o` equals the base plus the lowest pin index that has either pending bit set, taken modulo 256.
- R10: Clearing enable bits does not remove flags that are already pending.
- R11: A pin with both lane enables set records a rise in bit n and a later fall in bit n+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 7 | Asynchronous input pins |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Word address: 0 enable, 1 clear/pending, 2 vector base |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request, high while any flag is pending |
| vector_o | output | 8 | Base plus the index of the lowest pending pin |

## Verification
The pins are driven with a mix of transitions: a rise on a lane that is not enabled, falls and rises on pins that have only one lane enabled, and both transitions on a pin that has both lanes enabled. This separates the rising lane from the falling lane, and an enabled lane from a disabled one. Several pins are left pending at once, so the vector checks show whether the lowest index is chosen rather than the newest. A base near 255 shows the wrap. Clear writes of zero, a clear write of a single bit, and a clear write that lands in the same cycle as a new transition tell apart a write-one-to-clear register, a plain overwrite, and the wrong priority between clear and set.

// File: rtl/gpio_edge_intc.sv
module gpio_edge_intc #(
  parameter int NPIN = 7,
  parameter int LANE = 8,
  parameter int VW   = 8,
  parameter int AW   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIN-1:0]     pins_i,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [2*LANE-1:0]   bus_wdata,
  output logic [2*LANE-1:0]   bus_rdata,
  output logic                irq_o,
  output logic [VW-1:0]       vector_o
);
  localparam int RW = 2 * LANE;
  localparam int IW = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam logic [AW-1:0] A_EN   = AW'(0);
  localparam logic [AW-1:0] A_CLR  = AW'(1);
  localparam logic [AW-1:0] A_BASE = AW'(2);
  localparam logic [LANE-1:0] PMASK = LANE'((64'd1 << NPIN) - 64'd1);
  localparam logic [RW-1:0]   EMASK = {PMASK, PMASK};

  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] rise, fall;
  logic [RW-1:0]   det, en_q, pend_q, clr_bits;
  logic [VW-1:0]   base_q;
  logic [NPIN-1:0] hit;
  logic [IW-1:0]   idx;
  logic            wr_en, wr_clr, wr_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pins_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  generate
    if (LANE > NPIN) begin : g_pad
      assign det = {{(LANE-NPIN){1'b0}}, fall, {(LANE-NPIN){1'b0}}, rise};
    end else begin : g_nopad
      assign det = {fall, rise};
    end
  endgenerate

  assign wr_en    = bus_sel && bus_wr && (bus_addr == A_EN);
  assign wr_clr   = bus_sel && bus_wr && (bus_addr == A_CLR);
  assign wr_base  = bus_sel && bus_wr && (bus_addr == A_BASE);
  assign clr_bits = wr_clr ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      base_q <= '0;
    end else begin
      if (wr_en)   en_q   <= bus_wdata & EMASK;
      if (wr_base) base_q <= bus_wdata[VW-1:0];
      pend_q <= ((pend_q & ~clr_bits) | (det & en_q)) & EMASK;
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_CLR:   bus_rdata = pend_q;
      A_BASE:  bus_rdata = {{(RW-VW){1'b0}}, base_q};
      default: bus_rdata = '0;
    endcase
  end

  assign hit   = pend_q[NPIN-1:0] | pend_q[LANE +: NPIN];
  assign irq_o = |pend_q;

  always_comb begin
    idx = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (hit[i]) idx = IW'(i);
  end

  assign vector_o = base_q + VW'(idx);
endmodule

// File: rtl/gpio_edge_intc_chk.sv
module gpio_edge_intc_chk #(
  parameter int NPIN = 7,
  parameter int LANE = 8,
  parameter int VW   = 8,
  parameter int AW   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [2*LANE-1:0] bus_wdata,
  input logic [2*LANE-1:0] bus_rdata,
  input logic              irq_o,
  input logic [VW-1:0]     vector_o,
  input logic [2*LANE-1:0] en_q,
  input logic [2*LANE-1:0] pend_q,
  input logic [2*LANE-1:0] det,
  input logic [VW-1:0]     base_q
);
  logic          clr_wr;
  logic [VW-1:0] vdiff;
  assign clr_wr = bus_sel && bus_wr && (bus_addr == AW'(1));
  assign vdiff  = vector_o - base_q;

  genvar b;
  generate
    for (b = 0; b < 2 * LANE; b++) begin : g_bit
      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[b]) |-> $past(en_q[b])); // R5
      AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[b] && !(clr_wr && bus_wdata[b])) |=> pend_q[b]); // R6
      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (det[b] && en_q[b]) |=> pend_q[b]); // R7
    end
  endgenerate

  AST_CLEAR_ALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((bus_wdata & pend_q) == pend_q) && ((det & en_q) == '0)) |=> !irq_o); // R8
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vdiff < VW'(NPIN))); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != AW'(2)) |-> (bus_rdata[LANE-1] == 1'b0 && bus_rdata[2*LANE-1] == 1'b0)); // R2
endmodule

bind gpio_edge_intc gpio_edge_intc_chk #(.NPIN(NPIN), .LANE(LANE), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .vector_o(vector_o),
  .en_q(en_q), .pend_q(pend_q), .det(det), .base_q(base_q)
);

// File: tb/gpio_edge_intc_test.sv
module gpio_edge_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pins = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [7:0]  vec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  gpio_edge_intc uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .vector_o(vec)
  );

  always begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {15'd0, irq};
        default: act = {8'd0, vec};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a;
    expect_item(0, exp, tag);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(posedge clk); #1;
    pins[p] = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    read_chk(2'd0, 16'h0000, "R1 enable");
    read_chk(2'd1, 16'h0000, "R1 pending");
    read_chk(2'd2, 16'h0000, "R1 base");
    expect_item(1, 16'h0000, "R1 irq");

    bus_write(2'd0, 16'hFFFF);
    read_chk(2'd0, 16'h7F7F, "R2 unused bits");
    bus_write(2'd0, 16'h0000);
    set_pin(0, 1'b1);
    read_chk(2'd1, 16'h0000, "R5 disabled rise");
    set_pin(0, 1'b0);

    bus_write(2'd0, 16'h2825);
    read_chk(2'd0, 16'h2825, "R2 readback");
    bus_write(2'd2, 16'h0040);
    read_chk(2'd2, 16'h0040, "R9 base");

    set_pin(3, 1'b1);
    read_chk(2'd1, 16'h0000, "R5 rise lane off");
    expect_item(1, 16'h0000, "R8 irq idle");
    set_pin(3, 1'b0);
    read_chk(2'd1, 16'h0800, "R4 fall pin3");
    expect_item(1, 16'h0001, "R8 irq set");
    expect_item(2, 16'h0043, "R9 vector pin3");

    set_pin(5, 1'b1);
    read_chk(2'd1, 16'h0820, "R3 rise pin5");
    expect_item(2, 16'h0043, "R9 lowest not newest");
    set_pin(0, 1'b1);
    read_chk(2'd1, 16'h0821, "R3 rise pin0");
    expect_item(2, 16'h0040, "R9 vector pin0");

    bus_write(2'd1, 16'h0001);
    read_chk(2'd1, 16'h0820, "R6 clear one bit");
    expect_item(2, 16'h0043, "R9 vector after clear");
    bus_write(2'd1, 16'h0000);
    read_chk(2'd1, 16'h0820, "R6 zero write");

    set_pin(5, 1'b0);
    read_chk(2'd1, 16'h2820, "R11 both edges");

    bus_write(2'd0, 16'h0000);
    read_chk(2'd1, 16'h2820, "R10 disable keeps");
    bus_write(2'd2, 16'h00FE);
    expect_item(2, 16'h0001, "R9 wrap");
    bus_write(2'd0, 16'h2825);

    bus_write(2'd1, 16'hFFFF);
    read_chk(2'd1, 16'h0000, "R6 clear all");
    expect_item(1, 16'h0000, "R8 irq clear");

    set_pin(2, 1'b1);
    read_chk(2'd1, 16'h0004, "R3 rise pin2");
    set_pin(2, 1'b0);
    read_chk(2'd1, 16'h0004, "R5 fall lane off");
    @(posedge clk); #1;
    pins[2] = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 16'h0004;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
    read_chk(2'd1, 16'h0004, "R7 edge wins");
    bus_write(2'd1, 16'h0004);
    read_chk(2'd1, 16'h0000, "R6 clear after R7");

    done = 1'b1;
    report();
  end
endmodule